// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A single control line does two jobs. Pulling it low starts a conversion. Raising it blanks the result and re-arms the block. While converting, the sequencer presents a trial code to an external DAC. It reads back a one-bit comparator verdict and settles one code bit per clock, working from the top bit down to bit 0. Each new trial bit is switched on first. It stays on if the comparator reports that the DAC output is not above the input, and it is switched off if the comparator reports that the DAC output is above the input.

Once bit 0 is settled, the final code is latched onto the result bus. An active-low ready flag drops at the same time, and an output-enable rises alongside it. The output-enable stands for the three-state drivers of a shared data bus. The digital code is plain binary in every analog range. Any bipolar offset is applied outside this block, and software reads the code as offset binary in that range.

The bit count is a parameter. A second parameter chooses whether the result bus reads zero while it is disabled or shows the stored register.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `ready_n` is 1, `result_oe` is 0, `trial_code` is 0 and `result` is 0.
- R2: In the blank state, sampling `blank_conv` low at a clock edge starts a conversion. From that edge onward, `trial_code` holds only its top bit (value 2^(WIDTH-1)).
- R3: While converting, exactly one new bit is tried per clock, from bit WIDTH-1 down to bit 0. The bits below the bit under test are 0.
- R4: At each clock edge during a conversion, the bit under test is cleared if `cmp_above` is 1 and kept if `cmp_above` is 0. The bit below it is then set.
- R5: `ready_n` falls at the (WIDTH+1)-th clock edge after the start edge, counting the start edge as the first. At that edge `result` takes the final code. With an ideal comparator (`cmp_above` = `trial_code` > input), the final code equals the input.
- R6: `result_oe` is high exactly when `ready_n` is low. With MASK_BUS=1 (the default), `result` reads 0 whenever `result_oe` is low.
- R7: Sampling `blank_conv` high while the result is shown has effect at that same edge: `ready_n` returns to 1, `result_oe` to 0, `result` to 0 and `trial_code` to 0.
- R8: Sampling `blank_conv` high in the middle of a conversion aborts it. `trial_code` returns to 0 and `ready_n` stays 1.
- R9: If `blank_conv` is high at the edge that would settle bit 0, the abort takes priority and `ready_n` stays 1.
- R10: Holding `blank_conv` low after completion does not start a new conversion. `result`, `ready_n` and `trial_code` hold their values.
- R11: `cmp_above` has no effect when no conversion is running, whether the block is blanked or showing a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_conv | input | 1 | 1 = blank and re-arm, 0 = convert |
| cmp_above | input | 1 | Comparator verdict: 1 when the DAC output is above the input |
| trial_code | output | WIDTH | Code presented to the external DAC |
| result | output | WIDTH | Converted code (bus data) |
| result_oe | output | 1 | Result bus drive enable |
| ready_n | output | 1 | Active-low conversion-complete flag |

## Verification
Two events can land on the same clock edge: the settling of bit 0 and the abort caused by the control line going high. The bench starts a conversion and raises `blank_conv` exactly in the cycle before the edge that would settle the last bit. It then requires `ready_n` to stay high and the bus to stay disabled. A second coincidence is also tested: the comparator toggles while the result is shown. Here the bench requires the code and the flags to hold. Every input code of the 10-bit range is converted through an ideal comparator model, and the full trial sequence and the latency are checked each time.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_BLANK = 2'd0,
      ST_CONV  = 2'd1,
      ST_SHOW  = 2'd2
   } sar_state_e;

   function automatic int unsigned idx_bits(input int unsigned w);
      return (w < 2) ? 1 : $clog2(w);
   endfunction

endpackage

// File: rtl/sar_bit_walker.sv
module sar_bit_walker #(
   parameter int unsigned WIDTH = 10,
   localparam int unsigned IW = sar_seq_pkg::idx_bits(WIDTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic             clear,
   input  logic             cmp_above,
   output logic [WIDTH-1:0] trial,
   output logic [WIDTH-1:0] trial_next,
   output logic             last
);

   logic [IW-1:0]    idx_q;
   logic [WIDTH-1:0] sel;
   logic [WIDTH-1:0] below;

   assign sel   = {{(WIDTH-1){1'b0}}, 1'b1} << idx_q;
   assign below = sel >> 1;
   assign last  = (idx_q == '0);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         if (sel[i])
            trial_next[i] = ~cmp_above;
         else if (below[i])
            trial_next[i] = 1'b1;
         else
            trial_next[i] = trial[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         trial <= '0;
         idx_q <= '0;
      end else if (load) begin
         trial <= {1'b1, {(WIDTH-1){1'b0}}};
         idx_q <= IW'(WIDTH - 1);
      end else if (step) begin
         trial <= trial_next;
         if (!last)
            idx_q <= idx_q - 1'b1;
      end
   end

   AST_TEST_BIT_SET: assert property (@(posedge clk) disable iff (rst) (step && !clear) |-> (trial & sel) != '0); // R3

   AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst) (step && !clear) |-> (trial & (sel - 1'b1)) == '0); // R3

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
   parameter int unsigned WIDTH    = 10,
   parameter bit          MASK_BUS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic             release_out,
   input  logic [WIDTH-1:0] code_in,
   output logic [WIDTH-1:0] result,
   output logic             result_oe,
   output logic             ready_n
);

   logic [WIDTH-1:0] held_q;
   logic             oe_q;
   logic             rdy_n_q;

   always_ff @(posedge clk) begin
      if (rst || release_out) begin
         held_q  <= '0;
         oe_q    <= 1'b0;
         rdy_n_q <= 1'b1;
      end else if (capture) begin
         held_q  <= code_in;
         oe_q    <= 1'b1;
         rdy_n_q <= 1'b0;
      end
   end

   assign result_oe = oe_q;
   assign ready_n   = rdy_n_q;

   if (MASK_BUS) begin : g_masked
      assign result = oe_q ? held_q : '0;
      AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst) !result_oe |-> result == '0); // R6
   end else begin : g_raw
      assign result = held_q;
   end

   AST_OE_WITH_READY: assert property (@(posedge clk) disable iff (rst) result_oe == !ready_n); // R6

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int unsigned WIDTH    = 10,
   parameter bit          MASK_BUS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             blank_conv,
   input  logic             cmp_above,
   output logic [WIDTH-1:0] trial_code,
   output logic [WIDTH-1:0] result,
   output logic             result_oe,
   output logic             ready_n
);
   import sar_seq_pkg::*;

   initial begin : chk_params
      assert (WIDTH >= 2 && WIDTH <= 32) else $error("sar_seq_ctrl: WIDTH out of range");
   end

   sar_state_e       state_q;
   logic             start;
   logic             step;
   logic             abort;
   logic             finish;
   logic             release_out;
   logic             last;
   logic [WIDTH-1:0] trial_next;

   assign start       = (state_q == ST_BLANK) && !blank_conv;
   assign step        = (state_q == ST_CONV)  && !blank_conv;
   assign abort       = (state_q == ST_CONV)  &&  blank_conv;
   assign finish      = step && last;
   assign release_out = (state_q == ST_SHOW)  &&  blank_conv;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_BLANK;
      end else begin
         unique case (state_q)
            ST_BLANK: if (start)       state_q <= ST_CONV;
            ST_CONV:  if (abort)       state_q <= ST_BLANK;
                      else if (finish) state_q <= ST_SHOW;
            ST_SHOW:  if (release_out) state_q <= ST_BLANK;
            default:                   state_q <= ST_BLANK;
         endcase
      end
   end

   sar_bit_walker #(.WIDTH(WIDTH)) u_walker (
      .clk        (clk),
      .rst        (rst),
      .load       (start),
      .step       (step),
      .clear      (abort || release_out),
      .cmp_above  (cmp_above),
      .trial      (trial_code),
      .trial_next (trial_next),
      .last       (last)
   );

   sar_out_stage #(.WIDTH(WIDTH), .MASK_BUS(MASK_BUS)) u_out (
      .clk         (clk),
      .rst         (rst),
      .capture     (finish),
      .release_out (release_out),
      .code_in     (trial_next),
      .result      (result),
      .result_oe   (result_oe),
      .ready_n     (ready_n)
   );

   AST_START_MSB: assert property (@(posedge clk) disable iff (rst) (state_q == ST_BLANK && !blank_conv) |=> trial_code == {1'b1, {(WIDTH-1){1'b0}}}); // R2

   AST_READY_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) $fell(ready_n) |-> ($past(state_q) == ST_CONV && !$past(blank_conv))); // R5

   AST_ABORT_NO_READY: assert property (@(posedge clk) disable iff (rst) (state_q == ST_CONV && blank_conv) |=> (ready_n && trial_code == '0)); // R8 R9

   AST_BLANK_RELEASES: assert property (@(posedge clk) disable iff (rst) (!ready_n && blank_conv) |=> (ready_n && !result_oe)); // R7

   AST_SHOW_HOLDS: assert property (@(posedge clk) disable iff (rst) (!ready_n && !blank_conv) |=> ($stable(result) && $stable(trial_code) && !ready_n)); // R10 R11

endmodule

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         blank_conv = 1'b1;
   logic         cmp_above;
   logic [W-1:0] trial_code;
   logic [W-1:0] result;
   logic         result_oe;
   logic         ready_n;

   int           vin = 0;
   logic         ovr_en = 1'b0;
   logic         ovr_val = 1'b0;
   int           checks = 0;
   int           errors = 0;

   always #10 clk = ~clk;

   assign cmp_above = ovr_en ? ovr_val : (int'(trial_code) > vin);

   sar_seq_ctrl #(.WIDTH(W), .MASK_BUS(1'b1)) uut (
      .clk        (clk),
      .rst        (rst),
      .blank_conv (blank_conv),
      .cmp_above  (cmp_above),
      .trial_code (trial_code),
      .result     (result),
      .result_oe  (result_oe),
      .ready_n    (ready_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Drive one conversion of value v; walks the trial sequence and checks latency.
   task automatic run_conv(input int v);
      int n = 0;
      vin = v;
      @(negedge clk) blank_conv = 1'b0;
      for (int s = 1; s <= 20; s++) begin
         @(negedge clk);
         if (s <= W) begin
            int idx = W - s;
            int exp = (v & ~((1 << (idx + 1)) - 1)) | (1 << idx);
            check(int'(trial_code) == exp, (s == 1) ? "R2" : "R3/R4 trial", int'(trial_code), exp);
         end
         if (!ready_n) begin
            n = s;
            break;
         end
      end
      check(n == W + 1, "R5 latency", n, W + 1);
      check(int'(result) == v, "R5 code", int'(result), v);
      check(result_oe == 1'b1, "R6 oe", int'(result_oe), 1);
   endtask

   task automatic show_and_release(input int v);
      ovr_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk) ovr_val = k[0];
         @(negedge clk);
         check(int'(result) == v && !ready_n, "R10 hold", int'(result), v);
         check(int'(trial_code) == v, "R11 cmp ignored in show", int'(trial_code), v);
      end
      ovr_en = 1'b0;
      blank_conv = 1'b1;
      @(negedge clk);
      check(ready_n == 1'b1 && result_oe == 1'b0, "R7 flags", int'({ready_n, result_oe}), 2);
      check(result == '0 && trial_code == '0, "R7 cleared", int'(result) + int'(trial_code), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(ready_n == 1'b1 && result_oe == 1'b0, "R1 flags in reset", int'({ready_n, result_oe}), 2);
      check(trial_code == '0 && result == '0, "R1 buses in reset", int'(trial_code), 0);
      rst = 1'b0;
      @(negedge clk);
      check(ready_n == 1'b1 && trial_code == '0, "R1 after reset", int'(trial_code), 0);

      // R11: comparator toggling while blanked changes nothing
      ovr_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) ovr_val = k[0];
         check(trial_code == '0 && ready_n, "R11 cmp ignored in blank", int'(trial_code), 0);
      end
      ovr_en = 1'b0;

      // Exhaustive sweep of the code range
      for (int v = 0; v < (1 << W); v++) begin
         run_conv(v);
         show_and_release(v);
      end

      // R8: abort mid-conversion
      vin = 300;
      @(negedge clk) blank_conv = 1'b0;
      repeat (5) @(negedge clk);
      blank_conv = 1'b1;
      @(negedge clk);
      check(trial_code == '0, "R8 trial cleared", int'(trial_code), 0);
      for (int k = 0; k < 15; k++) begin
         @(negedge clk);
         check(ready_n == 1'b1 && result_oe == 1'b0, "R8 no ready", int'(ready_n), 1);
      end

      // R9: abort in the cycle that would settle bit 0
      vin = 777;
      @(negedge clk) blank_conv = 1'b0;
      repeat (W) @(negedge clk);
      check(int'(trial_code) == (777 & ~1) + 1, "R9 at last bit", int'(trial_code), (777 & ~1) + 1);
      blank_conv = 1'b1;
      @(negedge clk);
      check(ready_n == 1'b1 && result_oe == 1'b0, "R9 abort wins", int'(ready_n), 1);
      check(result == '0 && trial_code == '0, "R9 buses", int'(result), 0);
      repeat (3) @(negedge clk);
      check(ready_n == 1'b1, "R9 stays blank", int'(ready_n), 1);

      // A fresh conversion still works after an abort
      run_conv(512);
      show_and_release(512);

      summary();
      $finish;
   end
endmodule